// File: doc/BRIEF.md
# Fetch-Stage Taken-Branch Target Cache

This block is a small, fully associative cache consulted with the fetch address in the same cycle that the fetch address is presented. An entry exists only for a branch that is expected to be taken, so a match is the taken prediction. On a match the stored destination becomes the next fetch address. On a miss fetch continues with the sequential address.

Later in the pipeline, once a branch is decoded and resolved, a resolve port reports four things: the instruction address, whether it is a branch, whether it was taken, and its real destination. The port also carries the match flag that was captured at fetch time. From these inputs the block inserts, retargets or removes entries. When the fetch path was wrong, it raises a one-cycle redirect carrying the correct address.

Each wrong path costs two cycles in the surrounding pipeline, one for the bad fetch and one for the restart. A correct path costs nothing.

Top module: `btb_fetch`

## Requirements
- R1: After the active-low asynchronous reset, every entry is invalid: no fetch address matches and `redirect_o` is low.
- R2: When `fetch_valid_i` is high and the fetch address matches no valid entry, `pred_hit_o` is 0 and `next_pc_o` equals `fetch_pc_i + 4` in the same cycle. When `fetch_valid_i` is low, `pred_hit_o` is 0.
- R3: When `fetch_valid_i` is high and the fetch address equals the tag of a valid entry, `pred_hit_o` is 1 and `next_pc_o` equals that entry's stored target in the same cycle.
- R4: A resolve with fetch-time flag 0 that turns out to be a taken branch writes the address and its target into the buffer. On the next cycle it pulses `redirect_o` with `redirect_pc_o` set to the actual target.
- R5: A resolve with fetch-time flag 0 that is not a taken branch (a non-branch, or a branch not taken) leaves the contents unchanged and raises no redirect.
- R6: A resolve with fetch-time flag 1 whose branch is taken to the stored target leaves the entry in place and raises no redirect.
- R7: A resolve with fetch-time flag 1 that is not a taken branch removes the matching entry. On the next cycle it pulses `redirect_o` with `redirect_pc_o` set to the resolve address plus 4.
- R8: A resolve with fetch-time flag 1 whose branch is taken to a target other than the stored one overwrites the stored target. On the next cycle it redirects to the actual target.
- R9: A new entry goes to the lowest-numbered invalid slot. When all 8 slots are valid, it replaces the slot named by a rotating pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, after each such replacement.
- R10: A write for an address that is already held updates that entry in place and never creates a second entry for the same address.
- R11: `redirect_o` is high only in the cycle right after a resolve cycle that demands a redirect. At all other times it is low.
- R12: A fetch lookup in the same cycle as a resolve update sees the contents from before the update. The change is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | A fetch address is presented this cycle |
| fetch_pc_i | input | 32 | Fetch address |
| pred_hit_o | output | 1 | Fetch address matches a held taken branch |
| next_pc_o | output | 32 | Predicted next fetch address |
| res_valid_i | input | 1 | A resolved instruction is reported this cycle |
| res_pc_i | input | 32 | Address of the resolved instruction |
| res_is_br_i | input | 1 | Resolved instruction is a branch |
| res_taken_i | input | 1 | Branch was taken |
| res_target_i | input | 32 | Actual branch destination |
| res_hit_i | input | 1 | Match flag captured when this instruction was fetched |
| redirect_o | output | 1 | Flush the wrong path and restart fetch |
| redirect_pc_o | output | 32 | Address to restart fetch from |

## Verification
The bench targets these corner cases:
- A fetch and an update for the same address in one cycle. A design that forwards the write would hit a cycle early.
- A taken branch whose destination moved. A design that compares only tags would stay silent and keep the stale target.
- A not-taken resolve on a matching entry. A design that forgets to invalidate would keep predicting taken.
- Overfilling the table, where a wrong victim choice shows up as the wrong surviving addresses.
- Reinserting an address that is already held. A duplicating design would evict a live entry.

A long random run over a small address pool then mixes all resolve cases with stale fetch-time flags.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    RES_IDLE,
    RES_WRITE,
    RES_DROP
  } res_act_e;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PC_W    = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  fetch_pc_i,
  output logic             fetch_hit_o,
  output logic [PC_W-1:0]  fetch_tgt_o,
  input  logic [PC_W-1:0]  look_pc_i,
  output logic             look_hit_o,
  output logic [IDX_W-1:0] look_idx_o,
  output logic [PC_W-1:0]  look_tgt_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PC_W-1:0]  wr_tag_i,
  input  logic [PC_W-1:0]  wr_tgt_i,
  input  logic             inv_en_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  output logic [ENTRIES-1:0] valid_o
);
  logic [ENTRIES-1:0] vld_q;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [ENTRIES-1:0] f_match, l_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        tgt_q[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_tag_i;
        tgt_q[g] <= wr_tgt_i;
      end else if (inv_en_i && inv_idx_i == IDX_W'(g)) begin
        vld_q[g] <= 1'b0;
      end
    end
    assign f_match[g] = vld_q[g] && (tag_q[g] == fetch_pc_i);
    assign l_match[g] = vld_q[g] && (tag_q[g] == look_pc_i);
  end

  always_comb begin
    fetch_tgt_o = '0;
    look_tgt_o  = '0;
    look_idx_o  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (f_match[i]) fetch_tgt_o = fetch_tgt_o | tgt_q[i];
      if (l_match[i]) begin
        look_tgt_o = look_tgt_o | tgt_q[i];
        look_idx_o = look_idx_o | IDX_W'(i);
      end
    end
  end

  assign fetch_hit_o = |f_match;
  assign look_hit_o  = |l_match;
  assign valid_o     = vld_q;
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               alloc_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] rr_q, free_idx;
  logic             full;

  assign full = &valid_i;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim_o = full ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (alloc_i && full)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INSN_BYTES = 4,
  localparam int unsigned IDX_W     = $clog2(ENTRIES)
) (
  input  logic             res_valid_i,
  input  logic [PC_W-1:0]  res_pc_i,
  input  logic             res_is_br_i,
  input  logic             res_taken_i,
  input  logic [PC_W-1:0]  res_target_i,
  input  logic             res_hit_i,
  input  logic             look_hit_i,
  input  logic [IDX_W-1:0] look_idx_i,
  input  logic [PC_W-1:0]  look_tgt_i,
  input  logic [IDX_W-1:0] victim_i,
  output btb_pkg::res_act_e act_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             alloc_o,
  output logic             redir_o,
  output logic [PC_W-1:0]  redir_pc_o
);
  import btb_pkg::*;
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  logic taken, same_tgt;
  assign taken    = res_is_br_i && res_taken_i;
  assign same_tgt = res_hit_i && look_hit_i && (look_tgt_i == res_target_i);

  always_comb begin
    act_o      = RES_IDLE;
    idx_o      = look_hit_i ? look_idx_i : victim_i;
    alloc_o    = 1'b0;
    redir_o    = 1'b0;
    redir_pc_o = res_target_i;
    if (res_valid_i) begin
      if (taken && !same_tgt) begin
        act_o   = RES_WRITE;
        alloc_o = !look_hit_i;
        redir_o = 1'b1;
      end else if (!taken && res_hit_i) begin
        // stale flag: entry may already be gone, restart still needed
        act_o      = look_hit_i ? RES_DROP : RES_IDLE;
        redir_o    = 1'b1;
        redir_pc_o = res_pc_i + STEP;
      end
    end
  end
endmodule

// File: rtl/btb_fetch.sv
module btb_fetch #(
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_valid_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_hit_o,
  output logic [PC_W-1:0] next_pc_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_is_br_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic            res_hit_i,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  import btb_pkg::*;
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  logic               f_hit, l_hit, alloc, redir;
  logic [PC_W-1:0]    f_tgt, l_tgt, redir_pc;
  logic [IDX_W-1:0]   l_idx, victim, act_idx;
  logic [ENTRIES-1:0] valid;
  res_act_e           act;

  btb_store #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_pc_i  (fetch_pc_i),
    .fetch_hit_o (f_hit),
    .fetch_tgt_o (f_tgt),
    .look_pc_i   (res_pc_i),
    .look_hit_o  (l_hit),
    .look_idx_o  (l_idx),
    .look_tgt_o  (l_tgt),
    .wr_en_i     (act == RES_WRITE),
    .wr_idx_i    (act_idx),
    .wr_tag_i    (res_pc_i),
    .wr_tgt_i    (res_target_i),
    .inv_en_i    (act == RES_DROP),
    .inv_idx_i   (act_idx),
    .valid_o     (valid)
  );

  btb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid),
    .alloc_i  (alloc),
    .victim_o (victim)
  );

  btb_resolve #(.ENTRIES(ENTRIES), .PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_resolve (
    .res_valid_i  (res_valid_i),
    .res_pc_i     (res_pc_i),
    .res_is_br_i  (res_is_br_i),
    .res_taken_i  (res_taken_i),
    .res_target_i (res_target_i),
    .res_hit_i    (res_hit_i),
    .look_hit_i   (l_hit),
    .look_idx_i   (l_idx),
    .look_tgt_i   (l_tgt),
    .victim_i     (victim),
    .act_o        (act),
    .idx_o        (act_idx),
    .alloc_o      (alloc),
    .redir_o      (redir),
    .redir_pc_o   (redir_pc)
  );

  assign pred_hit_o = fetch_valid_i && f_hit;
  assign next_pc_o  = pred_hit_o ? f_tgt : fetch_pc_i + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      redirect_o    <= redir;
      redirect_pc_o <= redir ? redir_pc : redirect_pc_o;
    end
  end
endmodule

// File: rtl/btb_fetch_chk.sv
module btb_fetch_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fetch_valid_i,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            pred_hit_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            res_valid_i,
  input logic [PC_W-1:0] res_pc_i,
  input logic            res_is_br_i,
  input logic            res_taken_i,
  input logic [PC_W-1:0] res_target_i,
  input logic            res_hit_i,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  assert_miss_seq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && !pred_hit_o) |-> next_pc_o == fetch_pc_i + STEP);

  assert_idle_no_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> !pred_hit_o);

  assert_insert_seen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_is_br_i && res_taken_i) |=>
      (!(fetch_valid_i && fetch_pc_i == $past(res_pc_i)) ||
       (pred_hit_o && next_pc_o == $past(res_target_i))));

  assert_quiet_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_hit_i && !(res_is_br_i && res_taken_i)) |=> !redirect_o);

  assert_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_hit_i && !(res_is_br_i && res_taken_i)) |=>
      (redirect_o && redirect_pc_o == $past(res_pc_i) + STEP &&
       !(fetch_valid_i && fetch_pc_i == $past(res_pc_i) && pred_hit_o)));

  assert_redirect_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(res_valid_i));
endmodule

bind btb_fetch btb_fetch_chk #(.PC_W(PC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .fetch_pc_i    (fetch_pc_i),
  .pred_hit_o    (pred_hit_o),
  .next_pc_o     (next_pc_o),
  .res_valid_i   (res_valid_i),
  .res_pc_i      (res_pc_i),
  .res_is_br_i   (res_is_br_i),
  .res_taken_i   (res_taken_i),
  .res_target_i  (res_target_i),
  .res_hit_i     (res_hit_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o)
);

// File: tb/btb_fetch_tb.sv
`timescale 1ns/1ps
module btb_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0, rv = 1'b0, rbr = 1'b0, rtk = 1'b0, rhit = 1'b0;
  logic [31:0] fpc = '0, rpc = '0, rtgt = '0;
  logic        pred_hit, redir;
  logic [31:0] next_pc, redir_pc;

  int total = 0, bad = 0;
  bit done = 0;
  string ctx = "";

  bit          m_v   [8];
  logic [31:0] m_tag [8];
  logic [31:0] m_tgt [8];
  int          m_rr = 0;
  bit          e_redir = 0;
  logic [31:0] e_rpc = '0;
  string       e_tag = "R1";

  always #10 clk = ~clk;

  btb_fetch dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fv), .fetch_pc_i(fpc),
    .pred_hit_o(pred_hit), .next_pc_o(next_pc),
    .res_valid_i(rv), .res_pc_i(rpc), .res_is_br_i(rbr), .res_taken_i(rtk),
    .res_target_i(rtgt), .res_hit_i(rhit),
    .redirect_o(redir), .redirect_pc_o(redir_pc)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int find(logic [31:0] pc);
    for (int i = 0; i < 8; i++) if (m_v[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  function automatic int pick_slot();
    for (int i = 0; i < 8; i++) if (!m_v[i]) return i;
    begin
      int s = m_rr;
      m_rr = (m_rr + 1) % 8;
      return s;
    end
  endfunction

  task automatic step(bit f_v, logic [31:0] f_pc, bit r_v, logic [31:0] r_pc,
                      bit r_br, bit r_tk, logic [31:0] r_tg, bit r_h);
    int j;
    bit tk;
    string ft;
    @(negedge clk);
    fv = f_v; fpc = f_pc; rv = r_v; rpc = r_pc;
    rbr = r_br; rtk = r_tk; rtgt = r_tg; rhit = r_h;
    #1;
    j = f_v ? find(f_pc) : -1;
    ft = (j >= 0) ? "R3" : "R2";
    if (r_v && r_pc == f_pc) ft = "R12";
    if (ctx != "") ft = ctx;
    chk(pred_hit == (j >= 0), ft, {31'b0, pred_hit}, {31'b0, j >= 0});
    if (f_v) chk(next_pc == ((j >= 0) ? m_tgt[j] : f_pc + 4), ft, next_pc,
                 (j >= 0) ? m_tgt[j] : f_pc + 4);
    chk(redir == e_redir, e_tag, {31'b0, redir}, {31'b0, e_redir});
    if (e_redir) chk(redir_pc == e_rpc, e_tag, redir_pc, e_rpc);
    @(posedge clk);
    e_redir = 0; e_tag = "R11";
    if (r_v) begin
      tk = r_br && r_tk;
      j = find(r_pc);
      if (tk && !(r_h && j >= 0 && m_tgt[j] == r_tg)) begin
        if (j < 0) j = pick_slot();
        m_v[j] = 1; m_tag[j] = r_pc; m_tgt[j] = r_tg;
        e_redir = 1; e_rpc = r_tg; e_tag = r_h ? "R8" : "R4";
      end else if (!tk && r_h) begin
        if (j >= 0) m_v[j] = 0;
        e_redir = 1; e_rpc = r_pc + 4; e_tag = "R7";
      end else begin
        e_tag = tk ? "R6" : "R5";
      end
    end
  endtask

  task automatic fetch(logic [31:0] pc);
    step(1, pc, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic resolve(logic [31:0] pc, bit br, bit tk, logic [31:0] tg, bit h);
    step(0, 0, 1, pc, br, tk, tg, h);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; end
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R1: empty after reset
    ctx = "R1";
    fetch(32'h100); fetch(32'h0);
    ctx = "";
    // R2 miss, R4 insert, R3 hit
    fetch(32'h200);
    resolve(32'h200, 1, 1, 32'h4000, 0);
    fetch(32'h200);
    fetch(32'h204);
    // R12: same-cycle insert and fetch
    step(1, 32'h300, 1, 32'h300, 1, 1, 32'h5000, 0);
    fetch(32'h300);
    // R5: non-branch and not-taken misses
    resolve(32'h400, 0, 1, 32'h6000, 0);
    resolve(32'h404, 1, 0, 32'h6000, 0);
    fetch(32'h400); fetch(32'h404);
    // R6: correct hit
    resolve(32'h200, 1, 1, 32'h4000, 1);
    fetch(32'h200);
    // R8: target moved
    resolve(32'h200, 1, 1, 32'h4400, 1);
    fetch(32'h200);
    // R7: not taken on hit
    resolve(32'h200, 1, 0, 32'h4400, 1);
    fetch(32'h200);
    resolve(32'h300, 0, 0, 32'h0, 1);
    fetch(32'h300);
    // R9: fill and overflow
    for (int k = 0; k < 11; k++) resolve(32'h1000 + k * 16, 1, 1, 32'h8000 + k * 4, 0);
    ctx = "R9";
    for (int k = 0; k < 11; k++) fetch(32'h1000 + k * 16);
    resolve(32'h1050, 1, 0, 0, 1);
    resolve(32'h2000, 1, 1, 32'h9000, 0);
    for (int k = 0; k < 11; k++) fetch(32'h1000 + k * 16);
    fetch(32'h2000);
    // R10: reinsert a held address
    ctx = "R10";
    resolve(32'h1040, 1, 1, 32'h9100, 0);
    for (int k = 0; k < 11; k++) fetch(32'h1000 + k * 16);
    fetch(32'h2000);
    ctx = "";
    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, b;
      bit h;
      a = 32'h3000 + ($urandom % 12) * 4;
      b = 32'h3000 + ($urandom % 12) * 4;
      h = ($urandom % 5 == 0) ? bit'($urandom % 2) : (find(b) >= 0);
      step(bit'($urandom % 4 != 0), a, bit'($urandom % 3 != 0), b,
           bit'($urandom % 4 != 0), bit'($urandom % 2),
           32'hA000 + ($urandom % 3) * 64, h);
    end
    fetch(32'h0);
    fetch(32'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule